// File: doc/BRIEF.md
# Key-Committed Partition Clock Controller

This block holds the clock and output-safe-state settings for a small set of power partitions. Software writes a wanted configuration into each partition's register group and picks the fields that should change by setting update flags. A separate module clock-enable mask can also be written. None of these writes reaches the outputs straight away.

The changes take effect only after a two-word key sequence is written to a single control register. A fixed number of cycles after the second key is accepted, every partition with raised update flags copies the flagged fields into its active state. The active state drives the partition clock-enable, safe-state and module clock-enable outputs. It can also be read back through per-partition status registers, which software polls until they match the configuration.

Reads on the register bus are combinational. Writes are taken on the rising clock edge while `we_i` is high.

Top module: `pcc_ctrl`

## Requirements
- R1: After reset, partition 0 has its clock active and its safe state released. Its config reads 0x1 and its status reads 0x1. Every other partition has its clock off and its safe state asserted, with config and status both reading 0x4. All update flags, module requests and module outputs are zero.
- R2: Address map and encoding. The key register is at 0x000. Partition p's group begins at 0x100 + p*0x200. Within a group, the offsets are: config +0x00, update flags +0x04, status +0x08, module clock status +0x10, module clock request +0x30. In config, update flags and status, bit 0 is the clock field and bit 2 is the safe-state field. All other bits of these three registers read as zero. The module request register keeps its low MOD_W bits.
- R3: A write to config, update flags or module request leaves the outputs and the status registers unchanged until a commit is applied.
- R4: A commit is a write of 0x00005AF0 to the key register and then a write of 0x0000A50F to it. Writes to other registers may fall between the two. The outputs change on the second rising edge after the edge that accepts 0x0000A50F.
- R5: A key-register write that is not the next expected key ends the sequence with no commit. This covers a wrong value, 0x0000A50F sent first, and 0x00005AF0 sent twice in a row. A fresh 0x00005AF0 is then needed.
- R6: At a commit, only the fields with a raised update flag take the config value. The other fields keep their active value.
- R7: Every update flag reads zero once a commit has been applied.
- R8: The module clock outputs and module clock status change only at a commit that updates the clock field. At that point they take the request mask if the committed clock bit is 1, and zero if it is 0.
- R9: A single commit applies the flagged fields of all partitions in the same cycle.
- R10: After a commit, each flagged status bit equals the matching config bit.
- R11: Reads of unmapped addresses return zero. This includes partition groups with index NUM_PART or higher. Writes to unmapped addresses change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| part_clk_o | output | NUM_PART | Active partition clock enables |
| part_safe_o | output | NUM_PART | Active output-safe-state enables |
| mod_clk_o | output | NUM_PART*MOD_W | Active module clock enables, MOD_W bits per partition |

## Verification
Some properties are checked by assertions on every cycle. Outputs move only in the cycle after an apply pulse, and each apply lies exactly two cycles after a key acceptance. Update flags are clear after every apply, and module clocks stay zero while their partition clock is off. The bench scenarios cover the rest: the exact key orderings that arm or abort a commit, the selective field update, the register encodings, and the read-back of status after commits mixed with random register traffic.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h0000_5AF0;
  localparam logic [31:0] KEY_SECOND = 32'h0000_A50F;
  localparam int unsigned COMMIT_LAT = 2;

  localparam logic [7:0] OFF_CFG   = 8'h00;
  localparam logic [7:0] OFF_UPD   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_MSTAT = 8'h10;
  localparam logic [7:0] OFF_MREQ  = 8'h30;

  localparam int unsigned BIT_CLK  = 0;
  localparam int unsigned BIT_SAFE = 2;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/pcc_key_seq.sv
module pcc_key_seq
  import pcc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic [31:0] wdata_i,
  output logic        armed_o,
  output logic        accept_o,
  output logic        apply_o
);
  key_state_e state_q, state_d;
  logic [COMMIT_LAT-1:0] pipe_q;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    if (key_wr_i) begin
      if (state_q == KS_IDLE) begin
        state_d = (wdata_i == KEY_FIRST) ? KS_ARMED : KS_IDLE;
      end else begin
        // any key write while armed leaves the armed state
        accept_o = (wdata_i == KEY_SECOND);
        state_d  = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      pipe_q  <= '0;
    end else begin
      state_q <= state_d;
      pipe_q  <= {pipe_q[COMMIT_LAT-2:0], accept_o};
    end
  end

  assign armed_o = (state_q == KS_ARMED);
  assign apply_o = pipe_q[COMMIT_LAT-1];
endmodule

// File: rtl/pcc_part.sv
module pcc_part
  import pcc_pkg::*;
#(
  parameter int unsigned MOD_W    = 8,
  parameter bit          RST_CLK  = 1'b0,
  parameter bit          RST_SAFE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       off_i,
  input  logic [31:0]      wdata_i,
  input  logic             apply_i,
  output logic [31:0]      rdata_o,
  output logic             clk_o,
  output logic             safe_o,
  output logic [MOD_W-1:0] mod_o,
  output logic             upd_pend_o
);
  logic cfg_clk_q, cfg_safe_q, upd_clk_q, upd_safe_q, act_clk_q, act_safe_q;
  logic [MOD_W-1:0] mreq_q, mact_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_clk_q  <= RST_CLK;
      cfg_safe_q <= RST_SAFE;
      act_clk_q  <= RST_CLK;
      act_safe_q <= RST_SAFE;
      upd_clk_q  <= 1'b0;
      upd_safe_q <= 1'b0;
      mreq_q     <= '0;
      mact_q     <= '0;
    end else begin
      if (we_i && off_i == OFF_CFG) begin
        cfg_clk_q  <= wdata_i[BIT_CLK];
        cfg_safe_q <= wdata_i[BIT_SAFE];
      end
      if (we_i && off_i == OFF_MREQ) mreq_q <= wdata_i[MOD_W-1:0];
      if (apply_i) begin
        if (upd_clk_q) begin
          act_clk_q <= cfg_clk_q;
          mact_q    <= cfg_clk_q ? mreq_q : '0;
        end
        if (upd_safe_q) act_safe_q <= cfg_safe_q;
        upd_clk_q  <= 1'b0;
        upd_safe_q <= 1'b0;
      end else if (we_i && off_i == OFF_UPD) begin
        upd_clk_q  <= wdata_i[BIT_CLK];
        upd_safe_q <= wdata_i[BIT_SAFE];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_CFG:   begin rdata_o[BIT_CLK] = cfg_clk_q; rdata_o[BIT_SAFE] = cfg_safe_q; end
      OFF_UPD:   begin rdata_o[BIT_CLK] = upd_clk_q; rdata_o[BIT_SAFE] = upd_safe_q; end
      OFF_STAT:  begin rdata_o[BIT_CLK] = act_clk_q; rdata_o[BIT_SAFE] = act_safe_q; end
      OFF_MSTAT: rdata_o[MOD_W-1:0] = mact_q;
      OFF_MREQ:  rdata_o[MOD_W-1:0] = mreq_q;
      default:   rdata_o = '0;
    endcase
  end

  assign clk_o      = act_clk_q;
  assign safe_o     = act_safe_q;
  assign mod_o      = mact_q;
  assign upd_pend_o = upd_clk_q | upd_safe_q;
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned MOD_W    = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_PART-1:0]       part_clk_o,
  output logic [NUM_PART-1:0]       part_safe_o,
  output logic [NUM_PART*MOD_W-1:0] mod_clk_o
);
  localparam int unsigned IDX_W = ADDR_W - 9;

  logic              key_wr, key_armed, commit_accept, commit_apply;
  logic              grp_hit;
  logic [IDX_W-1:0]  grp_idx;
  logic [7:0]        grp_off;
  logic [NUM_PART-1:0] sel, upd_pend;
  logic [31:0]       part_rd [NUM_PART];

  assign key_wr  = we_i && (addr_i == '0);
  // group p occupies 0x100 + p*0x200 .. +0xFF
  assign grp_hit = addr_i[8];
  assign grp_idx = addr_i[ADDR_W-1:9];
  assign grp_off = addr_i[7:0];

  pcc_key_seq u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (key_wr),
    .wdata_i  (wdata_i),
    .armed_o  (key_armed),
    .accept_o (commit_accept),
    .apply_o  (commit_apply)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    assign sel[p] = grp_hit && (grp_idx == IDX_W'(p));
    pcc_part #(
      .MOD_W    (MOD_W),
      .RST_CLK  (p == 0),
      .RST_SAFE (p != 0)
    ) u_part (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (we_i && sel[p]),
      .off_i      (grp_off),
      .wdata_i    (wdata_i),
      .apply_i    (commit_apply),
      .rdata_o    (part_rd[p]),
      .clk_o      (part_clk_o[p]),
      .safe_o     (part_safe_o[p]),
      .mod_o      (mod_clk_o[p*MOD_W +: MOD_W]),
      .upd_pend_o (upd_pend[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (sel[p]) rdata_o = part_rd[p];
    end
  end
endmodule

// File: rtl/pcc_ctrl_chk.sv
module pcc_ctrl_chk #(
  parameter int unsigned NUM_PART = 4,
  parameter int unsigned MOD_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      armed_i,
  input logic                      accept_i,
  input logic                      apply_i,
  input logic [NUM_PART-1:0]       upd_pend_i,
  input logic [NUM_PART-1:0]       part_clk_i,
  input logic [NUM_PART-1:0]       part_safe_i,
  input logic [NUM_PART*MOD_W-1:0] mod_clk_i
);
  assert_out_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({part_clk_i, part_safe_i, mod_clk_i}) |-> $past(apply_i));

  assert_commit_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |-> $past(accept_i, 2));

  assert_disarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !armed_i);

  assert_flags_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (upd_pend_i == '0));

  for (genvar p = 0; p < NUM_PART; p++) begin : g_mod
    assert_mod_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !part_clk_i[p] |-> (mod_clk_i[p*MOD_W +: MOD_W] == '0));
  end
endmodule

bind pcc_ctrl pcc_ctrl_chk #(.NUM_PART(NUM_PART), .MOD_W(MOD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .armed_i     (key_armed),
  .accept_i    (commit_accept),
  .apply_i     (commit_apply),
  .upd_pend_i  (upd_pend),
  .part_clk_i  (part_clk_o),
  .part_safe_i (part_safe_o),
  .mod_clk_i   (mod_clk_o)
);

// File: tb/pcc_ctrl_tb.sv
module pcc_ctrl_tb;
  localparam int NP = 4;
  localparam int MW = 8;
  localparam int AW = 12;
  localparam logic [31:0] K1 = 32'h0000_5AF0;
  localparam logic [31:0] K2 = 32'h0000_A50F;

  logic clk = 1'b0, rst_ni = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] part_clk, part_safe;
  logic [NP*MW-1:0] mod_clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  bit m_cfg_clk[NP], m_cfg_safe[NP], m_upd_clk[NP], m_upd_safe[NP];
  bit m_act_clk[NP], m_act_safe[NP];
  bit [MW-1:0] m_mreq[NP], m_mact[NP];

  pcc_ctrl #(.NUM_PART(NP), .MOD_W(MW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .part_clk_o(part_clk), .part_safe_o(part_safe), .mod_clk_o(mod_clk)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] grp(int p, logic [7:0] off);
    return AW'(32'h100 + p * 32'h200 + off);
  endfunction

  function automatic logic [31:0] two_bits(bit b0, bit b2);
    return {29'd0, b2, 1'b0, b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic wr_cfg(int p, logic [31:0] d);
    wr(grp(p, 8'h00), d); m_cfg_clk[p] = d[0]; m_cfg_safe[p] = d[2];
  endtask
  task automatic wr_upd(int p, logic [31:0] d);
    wr(grp(p, 8'h04), d); m_upd_clk[p] = d[0]; m_upd_safe[p] = d[2];
  endtask
  task automatic wr_mreq(int p, logic [31:0] d);
    wr(grp(p, 8'h30), d); m_mreq[p] = d[MW-1:0];
  endtask

  task automatic model_apply();
    for (int p = 0; p < NP; p++) begin
      if (m_upd_clk[p]) begin
        m_act_clk[p] = m_cfg_clk[p];
        m_mact[p] = m_cfg_clk[p] ? m_mreq[p] : '0;
      end
      if (m_upd_safe[p]) m_act_safe[p] = m_cfg_safe[p];
      m_upd_clk[p] = 1'b0; m_upd_safe[p] = 1'b0;
    end
  endtask

  task automatic commit();
    wr('0, K1); wr('0, K2);
    @(negedge clk); @(negedge clk);
    model_apply();
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rd(grp(p, 8'h00), d); chk({tag, " cfg"}, d, two_bits(m_cfg_clk[p], m_cfg_safe[p]));
      rd(grp(p, 8'h04), d); chk({tag, " upd"}, d, two_bits(m_upd_clk[p], m_upd_safe[p]));
      rd(grp(p, 8'h08), d); chk({tag, " stat"}, d, two_bits(m_act_clk[p], m_act_safe[p]));
      rd(grp(p, 8'h10), d); chk({tag, " mstat"}, d, 32'(m_mact[p]));
      rd(grp(p, 8'h30), d); chk({tag, " mreq"}, d, 32'(m_mreq[p]));
      chk({tag, " clk_o"}, 32'(part_clk[p]), 32'(m_act_clk[p]));
      chk({tag, " safe_o"}, 32'(part_safe[p]), 32'(m_act_safe[p]));
      chk({tag, " mod_o"}, 32'(mod_clk[p*MW +: MW]), 32'(m_mact[p]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      m_cfg_clk[p] = (p == 0); m_cfg_safe[p] = (p != 0);
      m_act_clk[p] = (p == 0); m_act_safe[p] = (p != 0);
      m_upd_clk[p] = 0; m_upd_safe[p] = 0; m_mreq[p] = '0; m_mact[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 masking of unused bits
    wr_cfg(2, 32'hFFFF_FFFF); wr_upd(2, 32'hFFFF_FFFA); wr_mreq(2, 32'hFFFF_FF5A);
    check_all("R2 map");
    // R3 no effect without commit
    chk("R3 clk held", 32'(part_clk[2]), 32'd0);
    wr_upd(2, 32'h0);

    // R4 latency and interleaved write between the keys
    wr_cfg(1, 32'h1); wr_upd(1, 32'h1); wr_mreq(1, 32'h3C);
    wr('0, K1); wr(grp(3, 8'h30), 32'h11); m_mreq[3] = 8'h11;
    wr('0, K2);
    chk("R4 edge0", 32'(part_clk[1]), 32'd0);
    @(negedge clk);
    chk("R4 edge1", 32'(part_clk[1]), 32'd0);
    @(negedge clk);
    chk("R4 edge2", 32'(part_clk[1]), 32'd1);
    chk("R8 mod on", 32'(mod_clk[1*MW +: MW]), 32'h3C);
    model_apply();
    check_all("R10 after commit");

    // R5 aborted sequences
    wr_cfg(3, 32'h1); wr_upd(3, 32'h5);
    wr('0, K2); @(negedge clk); @(negedge clk);
    wr('0, K1); wr('0, 32'h1234); wr('0, K2); @(negedge clk); @(negedge clk);
    wr('0, K1); wr('0, K1); wr('0, K2); @(negedge clk); @(negedge clk);
    wr('0, 32'h0001_5AF0); wr('0, K2); @(negedge clk); @(negedge clk);
    check_all("R5 abort");

    // R6 only flagged field moves; R9 two partitions at once
    wr_upd(3, 32'h1); wr_cfg(2, 32'h0); wr_upd(2, 32'h4);
    commit();
    chk("R6 safe kept", 32'(part_safe[3]), 32'd1);
    chk("R9 p2 safe", 32'(part_safe[2]), 32'd0);
    chk("R7 flags", 32'(m_upd_clk[3]), 32'd0);
    check_all("R6 R7 R9");

    // R8 new request held until clock commit, then gated by clock off
    wr_mreq(1, 32'hA5);
    check_all("R8 held");
    wr_cfg(1, 32'h0); wr_upd(1, 32'h1); commit();
    chk("R8 mod off", 32'(mod_clk[1*MW +: MW]), 32'd0);
    check_all("R8 off");

    // R11 unmapped reads and writes
    rd(AW'(12'h050), d); chk("R11 hole", d, 32'd0);
    rd(AW'(12'h900), d); chk("R11 idx", d, 32'd0);
    wr(AW'(12'h900), 32'h5); wr(AW'(12'h904), 32'h5); wr(AW'(12'h0C0), 32'hFF);
    commit();
    check_all("R11 writes");

    // random traffic mixed with commits
    for (int i = 0; i < 300; i++) begin
      int p;
      p = int'($urandom % NP);
      case ($urandom % 6)
        0: wr_cfg(p, $urandom);
        1: wr_upd(p, $urandom);
        2: wr_mreq(p, $urandom);
        3: commit();
        4: begin wr('0, K1); wr('0, $urandom & 32'hFFFF_0000); end
        default: wr('0, K2);
      endcase
      if (i % 10 == 9) check_all("R10 random");
    end
    commit();
    check_all("R7 R10 final");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule